// File: doc/BRIEF.md
# Platform Timebase Counter with Supervisor Timer Compare

This block keeps the platform's wall-clock time as a 64-bit count in which one unit stands for 10 ns of elapsed time. The count is not tied to the rate at which it is advanced. It may be stepped at a slower tick rate, and each tick then adds the number of 10 ns units that the tick period spans. For a 10 MHz tick, each tick adds 10. The step is fixed when the block is built and must be at least 1, so every tick moves the count strictly forward.

A supervisor-level compare register sits beside the count and drives a level-sensitive timer interrupt. The interrupt is high whenever the time has reached or passed the compare value. Software acknowledges it by writing a later compare value.

A small register port lets software read either register as one 64-bit word. Each read is a snapshot captured on a single clock edge. Software can write the compare register. Writes aimed at the time register are dropped, so the count cannot be moved backwards from software.

Top module: `tbase_timer`

## Requirements
- R1: After a synchronous active-low reset, the time reads 0, the compare reads all ones, `timer_irq` is low and `reg_rvalid` is low.
- R2: Each clock edge with `tick_en` high adds STEP (default 10) to the time.
- R3: On a clock edge with `tick_en` low, the time keeps its value.
- R4: A write with `reg_sel`=0 (time register) leaves the time unchanged.
- R5: A write with `reg_sel`=1 (compare register) loads `reg_wdata` into the compare. Without such a write, the compare holds its value.
- R6: `timer_irq` is high exactly when time >= compare, and this includes the case where the two are equal.
- R7: Writing a compare value above the current time drops `timer_irq` from the first cycle after the write edge. `timer_irq` falls only after a compare write.
- R8: A clock edge with `reg_rd` high sets `reg_rvalid` high for the next cycle. On that cycle `reg_rdata` holds the value the selected register had just before that edge (`reg_sel`=0 time, 1 compare), even if a tick occurs on the same edge. Without a read, `reg_rdata` holds its value.
- R9: Successive time values are strictly increasing across ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance the time by STEP on this edge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 time, 1 compare |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| timer_irq | output | 1 | Level supervisor timer interrupt |

## Verification
The bench reads the time on the same edge that ticks it. A design that captured the read after the update, instead of before it, would return a value one step too high. It also sets the compare to land exactly on a tick value, which catches a comparison written as strictly-greater: such a design would hold the interrupt low for one extra tick. Writes to the time register are checked by reading the time back afterwards, which exposes a design that lets software move the count. A compare write to a later value is checked on the very next cycle, which exposes an interrupt that is latched or cleared late.

// File: rtl/tbase_pkg.sv
// Shared definitions for the timebase block.
// Assumes a single-bit register select on the software port.
package tbase_pkg;
    typedef enum logic {
        SEL_TIME = 1'b0,
        SEL_CMP  = 1'b1
    } tbase_sel_e;
endpackage

// File: rtl/tbase_counter.sv
// Free-running time count in 10 ns units.
// Adds STEP on each enabled tick and has no software write path.
// Assumes STEP >= 1, which is checked at elaboration.
module tbase_counter #(
    parameter int W    = 64,
    parameter int STEP = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] time_q
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    // Elaboration guard: a zero step would break monotonic advance
    if (STEP < 1) begin : g_bad_step
        $error("tbase_counter: STEP must be at least 1");
    end

    // Advance the count by one step per tick
    always_ff @(posedge clk) begin
        if (!rst_n)       time_q <= '0;
        else if (tick_en) time_q <= time_q + STEP_V;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(time_q)); // R3
    AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (time_q > $past(time_q))); // R9
endmodule

// File: rtl/tbase_compare.sv
// Supervisor compare register and level timer interrupt.
// Resets the compare to all ones so that no interrupt is raised out of reset.
// Assumes the time input never decreases.
module tbase_compare #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic [W-1:0] time_i,
    output logic [W-1:0] cmp_q,
    output logic         irq
);
    // Load a new compare value from software
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (cmp_wr) cmp_q <= cmp_wdata;
    end

    // Raise the interrupt while the time has reached the compare value
    always_comb irq = (time_i >= cmp_q);

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_wr |=> $stable(cmp_q)); // R5
    AST_IRQ_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(cmp_wr)); // R7
endmodule

// File: rtl/tbase_readport.sv
// Registered read port.
// Captures the selected register on the edge of the read strobe.
// Holds the data between reads.
module tbase_readport #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  logic         sel,
    input  logic [W-1:0] time_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] rdata,
    output logic         rvalid
);
    import tbase_pkg::*;

    // Snapshot the whole selected word in one edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= (tbase_sel_e'(sel) == SEL_CMP) ? cmp_i : time_i;
        end
    end

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R8
endmodule

// File: rtl/tbase_timer.sv
// Top of the timebase block.
// Connects the count, the compare and the read port.
// Only the compare register is writable from software.
module tbase_timer #(
    parameter int W    = 64,
    parameter int STEP = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic         reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         reg_rvalid,
    output logic         timer_irq
);
    import tbase_pkg::*;

    logic [W-1:0] time_w;
    logic [W-1:0] cmp_w;
    logic         cmp_wr;

    // Decode writes: only the compare select is accepted
    always_comb cmp_wr = reg_wr && (tbase_sel_e'(reg_sel) == SEL_CMP);

    tbase_counter #(.W(W), .STEP(STEP)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .time_q  (time_w)
    );

    tbase_compare #(.W(W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (reg_wdata),
        .time_i    (time_w),
        .cmp_q     (cmp_w),
        .irq       (timer_irq)
    );

    tbase_readport #(.W(W)) u_readport (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (reg_rd),
        .sel    (reg_sel),
        .time_i (time_w),
        .cmp_i  (cmp_w),
        .rdata  (reg_rdata),
        .rvalid (reg_rvalid)
    );

    AST_TIME_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !tick_en) |=> $stable(time_w)); // R4
endmodule

// File: tb/tbase_timer_tb.sv
// Directed bench for tbase_timer. Each task runs one scenario and checks its own results.
module tbase_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 64;
    localparam int STEP       = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick_en, reg_wr, reg_rd, reg_sel;
    logic [W-1:0] reg_wdata;
    logic [W-1:0] reg_rdata;
    logic         reg_rvalid, timer_irq;

    int           n_checks = 0;
    int           n_errors = 0;
    logic [W-1:0] exp_time = '0;
    logic [W-1:0] exp_cmp  = '1;

    tbase_timer #(.W(W), .STEP(STEP)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .timer_irq  (timer_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then sample just after the rising edge
    task automatic cyc(input bit tk, input bit wr, input bit rd, input bit sel,
                       input logic [W-1:0] wd);
        @(negedge clk);
        tick_en = tk; reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        #1;
        tick_en = 0; reg_wr = 0; reg_rd = 0; reg_sel = 0; reg_wdata = '0;
        if (tk) exp_time += W'(STEP);
        if (wr && sel) exp_cmp = wd;
    endtask

    task automatic read_chk(input bit sel, input logic [W-1:0] exp, input string req);
        cyc(0, 0, 1, sel, '0);
        check(reg_rvalid === 1'b1, req, W'(reg_rvalid), 1);
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        check(reg_rvalid === 1'b0, "R1 rvalid", W'(reg_rvalid), 0);
        check(timer_irq === 1'b0, "R1 irq", W'(timer_irq), 0);
        read_chk(0, '0, "R1 time");
        read_chk(1, '1, "R1 compare");
    endtask

    task automatic t_tick;
        logic [W-1:0] prev;
        cyc(1, 0, 1, 0, '0);
        prev = reg_rdata;
        for (int i = 0; i < 5; i++) begin
            cyc(1, 0, 1, 0, '0);
            check(reg_rdata > prev, "R9 monotonic", reg_rdata, prev + 1);
            check(reg_rdata === prev + W'(STEP), "R2 step", reg_rdata, prev + W'(STEP));
            prev = reg_rdata;
        end
        read_chk(0, exp_time, "R2 time");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, '0);
        read_chk(0, exp_time, "R3 idle hold");
    endtask

    task automatic t_time_write;
        cyc(0, 1, 0, 0, '0);
        read_chk(0, exp_time, "R4 write zero ignored");
        cyc(0, 1, 0, 0, 64'hFFFF_0000_1234_5678);
        read_chk(0, exp_time, "R4 write large ignored");
        read_chk(1, exp_cmp, "R4 compare untouched");
    endtask

    task automatic t_compare;
        cyc(0, 1, 0, 1, exp_time + 64'd30);
        read_chk(1, exp_cmp, "R5 compare readback");
        check(timer_irq === 1'b0, "R6 below", W'(timer_irq), 0);
        cyc(1, 0, 0, 0, '0);
        cyc(1, 0, 0, 0, '0);
        check(timer_irq === 1'b0, "R6 one step short", W'(timer_irq), 0);
        cyc(1, 0, 0, 0, '0);
        check(timer_irq === 1'b1, "R6 equal", W'(timer_irq), 1);
        cyc(1, 0, 0, 0, '0);
        check(timer_irq === 1'b1, "R6 past", W'(timer_irq), 1);
        cyc(0, 1, 0, 1, exp_time + 64'd100);
        check(timer_irq === 1'b0, "R7 clear next cycle", W'(timer_irq), 0);
        cyc(0, 0, 0, 0, '0);
        check(timer_irq === 1'b0, "R7 stays clear", W'(timer_irq), 0);
        cyc(0, 1, 0, 1, '0);
        check(timer_irq === 1'b1, "R6 compare zero", W'(timer_irq), 1);
        cyc(1, 0, 1, 1, '1);
        check(reg_rdata === 64'd0, "R8 snapshot before edge", reg_rdata, 0);
        cyc(1, 1, 0, 1, '1);
        check(timer_irq === 1'b0, "R7 all ones", W'(timer_irq), 0);
        read_chk(1, '1, "R5 final compare");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0; tick_en = 0; reg_wr = 0; reg_rd = 0; reg_sel = 0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tick();
        t_time_write();
        t_compare();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule